// File: doc/BRIEF.md
# Scalar Multiplication Sequencer

This block controls an elliptic-curve scalar multiplier over a binary field. It also connects that multiplier to a host. The host writes the curve parameter d, the three projective coordinates of the base point P and the scalar k over a 32-bit data bus, one word per clock. The host then starts a run.

The sequencer scans the scalar from its most significant set bit down to bit 0 with the left-to-right binary method. The accumulator Q starts as a copy of P at the top set bit. For each lower bit the sequencer issues one point doubling. If that bit is one, a point addition follows the doubling. Every operation goes to an external unified point-operation unit. The unit receives a one-cycle start strobe and a doubling or addition flag, and it gets a fixed slot of `OP_CYCLES` clocks. The result is written back into Q on the last clock of that slot. When the scan ends, the host reads Qx, Qy and Qz back as 32-bit words.

A single enable line freezes the whole block. A 4-bit mode code selects what the data bus does in each cycle. One status output pulses once per finished point operation. A second status output reports that the multiplication is complete.

Top module: `ecsm_sequencer`

## Requirements
- R1: While `en` is high and `mode` holds a load code, one `din` word is written per clock into the selected register, least significant word first. The load codes are 1 = d, 2 = Px, 3 = Py, 4 = Pz and 5 = scalar. An n-bit register takes ceil(n/32) words. The word index restarts at 0 on the first cycle of a new mode code and wraps after the last word. Bits of the top word above bit n-1 are dropped.
- R2: The read codes are 9 = Qx, 10 = Qy and 11 = Qz. While a read code is held, `dout` presents word i of the selected register one clock after the i-th cycle of that code, starting at word 0. Bits above n-1 in the top word read as zero.
- R3: Starting from Q = P at the highest set scalar bit, every lower bit causes one doubling, followed by one addition only when that bit is 1. The operations run from the top bit down.
- R4: In the first cycle of each operation slot, `pu_start` is high for exactly one enabled cycle. For the whole slot, exactly one of `pu_dbl` and `pu_add` is high, and it matches the operation in progress.
- R5: Each operation occupies exactly `OP_CYCLES` (20) enabled clocks. `op_stat` pulses in the last of them, and Q takes `pu_rx/ry/rz` at that edge. The next operation starts in the following cycle.
- R6: While `en` is low, nothing happens: no register is loaded, the scan does not advance and the status outputs hold.
- R7: While a run is in progress, load codes are ignored and a fresh start code is ignored.
- R8: After reset, `fin` is low. `fin` goes high when a run finishes and stays high until the next accepted start.
- R9: A scalar of 0 sets Q to all zeros and a scalar of 1 sets Q = P. In both cases `fin` rises in the cycle after the start with no operation issued.
- R10: A run starts only in the first enabled cycle in which `mode` becomes 8. Holding code 8 does not restart the run after it finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Block enable; low freezes everything |
| mode | input | 4 | Host mode code (load, start, read) |
| din | input | 32 | Host write data word |
| dout | output | 32 | Host read data word (registered) |
| op_stat | output | 1 | Pulse in the last cycle of each point operation |
| fin | output | 1 | Scalar multiplication complete |
| pu_start | output | 1 | Start strobe to the point unit |
| pu_dbl | output | 1 | Current operation is a doubling |
| pu_add | output | 1 | Current operation is an addition |
| pu_d | output | FIELD_W | Curve parameter d |
| pu_px | output | FIELD_W | Base point X |
| pu_py | output | FIELD_W | Base point Y |
| pu_pz | output | FIELD_W | Base point Z |
| pu_qx | output | FIELD_W | Accumulator X |
| pu_qy | output | FIELD_W | Accumulator Y |
| pu_qz | output | FIELD_W | Accumulator Z |
| pu_rx | input | FIELD_W | Operation result X |
| pu_ry | input | FIELD_W | Operation result Y |
| pu_rz | input | FIELD_W | Operation result Z |

## Verification
The bench replaces the point unit with a model in which a doubling doubles X and Y and an addition adds P. The Z coordinate counts doublings and additions separately. With this model the read-back Q is a closed form of k, so a sweep over every 8-bit scalar shows a scan that starts at the wrong bit, reverses the order or adds on zero bits as a wrong multiple of P. The sweep also shows a wrong operation count as a wrong Z value.

The scalars 0 and 1 are swept explicitly. A design that issues an operation for these values would double the point at infinity, or would leave a stale Q behind.

Padding ones in the top input word catch a load that keeps bits above n-1, or a readout that does not mask them. A load issued mid-run and a frozen enable window show whether the block lets a write corrupt P or keeps counting while it should hold. Holding the start code past the end of a run catches a block that restarts on a level instead of on entry.

// File: rtl/ecsm_pkg.sv
// Package: shared mode codes and operation kinds for the scalar
// multiplication sequencer. Assumes a 4-bit host mode bus.
package ecsm_pkg;
    localparam logic [3:0] M_IDLE  = 4'd0;
    localparam logic [3:0] M_LD_D  = 4'd1;
    localparam logic [3:0] M_LD_PX = 4'd2;
    localparam logic [3:0] M_LD_PY = 4'd3;
    localparam logic [3:0] M_LD_PZ = 4'd4;
    localparam logic [3:0] M_LD_K  = 4'd5;
    localparam logic [3:0] M_RUN   = 4'd8;
    localparam logic [3:0] M_RD_QX = 4'd9;
    localparam logic [3:0] M_RD_QY = 4'd10;
    localparam logic [3:0] M_RD_QZ = 4'd11;

    typedef enum logic {
        OPK_DBL = 1'b0,
        OPK_ADD = 1'b1
    } op_kind_e;
endpackage

// File: rtl/ecsm_host_port.sv
// Host port: holds d, P and the scalar, loads them word by word from the
// 32-bit bus, and serialises the accumulator Q onto the read bus.
// Assumes the word index restarts whenever the mode code changes; loads
// are blocked while the scan is busy.
module ecsm_host_port
    import ecsm_pkg::*;
#(
    parameter int FW  = 163,
    parameter int KW  = 163,
    parameter int BUS = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [3:0]    mode,
    input  logic [BUS-1:0] din,
    input  logic          busy,
    input  logic [FW-1:0] qx,
    input  logic [FW-1:0] qy,
    input  logic [FW-1:0] qz,
    output logic [FW-1:0] d,
    output logic [FW-1:0] px,
    output logic [FW-1:0] py,
    output logic [FW-1:0] pz,
    output logic [KW-1:0] k,
    output logic [BUS-1:0] dout,
    output logic          run_req
);
    localparam int FWORDS = (FW + BUS - 1) / BUS;
    localparam int KWORDS = (KW + BUS - 1) / BUS;
    localparam int MAXW   = (FWORDS > KWORDS) ? FWORDS : KWORDS;
    localparam int PTRW   = (MAXW > 1) ? $clog2(MAXW) : 1;

    logic [3:0]      prev_mode;
    logic [PTRW-1:0] ptr;
    int              wsel;
    int              limit;

    function automatic logic [FW-1:0] put_f(input logic [FW-1:0] old,
                                            input logic [BUS-1:0] w, input int idx);
        logic [FWORDS*BUS-1:0] t;
        t = '0;
        t[FW-1:0] = old;
        t[idx*BUS +: BUS] = w;
        return t[FW-1:0];
    endfunction

    function automatic logic [KW-1:0] put_k(input logic [KW-1:0] old,
                                            input logic [BUS-1:0] w, input int idx);
        logic [KWORDS*BUS-1:0] t;
        t = '0;
        t[KW-1:0] = old;
        t[idx*BUS +: BUS] = w;
        return t[KW-1:0];
    endfunction

    function automatic logic [BUS-1:0] get_f(input logic [FW-1:0] v, input int idx);
        logic [FWORDS*BUS-1:0] t;
        t = '0;
        t[FW-1:0] = v;
        return t[idx*BUS +: BUS];
    endfunction

    // Current word index and the word count of the addressed register.
    always_comb begin
        wsel  = (mode == prev_mode) ? int'(ptr) : 0;
        limit = (mode == M_LD_K) ? KWORDS : FWORDS;
    end

    // A start request exists only on entry into the start code.
    assign run_req = en && (mode == M_RUN) && (prev_mode != M_RUN);

    // Word pointer and mode history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_mode <= M_IDLE;
            ptr       <= '0;
        end else if (en) begin
            prev_mode <= mode;
            if (wsel + 1 >= limit) ptr <= '0;
            else                   ptr <= PTRW'(wsel + 1);
        end
    end

    // Operand loading, blocked while a run is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d  <= '0;
            px <= '0;
            py <= '0;
            pz <= '0;
            k  <= '0;
        end else if (en && !busy) begin
            case (mode)
                M_LD_D:  d  <= put_f(d,  din, wsel);
                M_LD_PX: px <= put_f(px, din, wsel);
                M_LD_PY: py <= put_f(py, din, wsel);
                M_LD_PZ: pz <= put_f(pz, din, wsel);
                M_LD_K:  k  <= put_k(k,  din, wsel);
                default: ;
            endcase
        end
    end

    // Registered readout of the accumulator, zero outside read codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (en) begin
            case (mode)
                M_RD_QX: dout <= get_f(qx, wsel);
                M_RD_QY: dout <= get_f(qy, wsel);
                M_RD_QZ: dout <= get_f(qz, wsel);
                default: dout <= '0;
            endcase
        end
    end

    assert_wr_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(px) && $stable(py) && $stable(pz) && $stable(d) && $stable(k)));

    assert_hold_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(px) && $stable(k) && $stable(dout)));
endmodule

// File: rtl/ecsm_op_timer.sv
// Operation slot timer: counts a fixed number of enabled cycles per
// point operation and marks the first and last cycle of each slot.
// Assumes a new launch only arrives when idle or in a slot's last cycle.
module ecsm_op_timer #(
    parameter int CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic launch,
    output logic active,
    output logic first,
    output logic last
);
    localparam int CW = (CYC > 2) ? $clog2(CYC) : 1;

    logic [CW-1:0] cnt;

    assign first = active && (cnt == '0);
    assign last  = active && (cnt == CW'(CYC - 1));

    // Slot counter: restart on launch, stop after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (en) begin
            if (launch) begin
                active <= 1'b1;
                cnt    <= '0;
            end else if (active) begin
                if (last) active <= 1'b0;
                else      cnt    <= cnt + 1'b1;
            end
        end
    end

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (!active || last));

    assert_full_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> ($past(cnt) == CW'(CYC - 1)));
endmodule

// File: rtl/ecsm_scan_fsm.sv
// Scan controller: left-to-right double-and-add over the scalar, starting
// at its top set bit with Q = P. Owns the accumulator Q and captures the
// point unit's result at the end of each slot. Assumes the scalar and P
// stay constant while busy.
module ecsm_scan_fsm
    import ecsm_pkg::*;
#(
    parameter int FW = 163,
    parameter int KW = 163
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          run_req,
    input  logic [KW-1:0] k,
    input  logic [FW-1:0] px,
    input  logic [FW-1:0] py,
    input  logic [FW-1:0] pz,
    input  logic [FW-1:0] rx,
    input  logic [FW-1:0] ry,
    input  logic [FW-1:0] rz,
    input  logic          last,
    output logic          launch,
    output op_kind_e      kind,
    output logic          busy,
    output logic          fin,
    output logic [FW-1:0] qx,
    output logic [FW-1:0] qy,
    output logic [FW-1:0] qz
);
    localparam int KIDX = (KW > 1) ? $clog2(KW) : 1;

    logic [KIDX-1:0] top;
    logic            found;
    logic [KIDX-1:0] idx;
    logic            more;

    // Locate the highest set scalar bit.
    always_comb begin
        top   = '0;
        found = 1'b0;
        for (int i = 0; i < KW; i++) begin
            if (k[i]) begin
                top   = KIDX'(i);
                found = 1'b1;
            end
        end
    end

    // Another operation follows the current one.
    assign more = ((kind == OPK_DBL) && k[idx]) || (idx != '0);

    // Launch a slot on a non-trivial start or on a continuing slot end.
    assign launch = en && ((!busy && run_req && found && (top != '0)) ||
                           (busy && last && more));

    // Scan state and accumulator update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            fin  <= 1'b0;
            idx  <= '0;
            kind <= OPK_DBL;
            qx   <= '0;
            qy   <= '0;
            qz   <= '0;
        end else if (en) begin
            if (!busy) begin
                if (run_req) begin
                    if (!found) begin
                        qx  <= '0;
                        qy  <= '0;
                        qz  <= '0;
                        fin <= 1'b1;
                    end else begin
                        qx <= px;
                        qy <= py;
                        qz <= pz;
                        if (top == '0) begin
                            fin <= 1'b1;
                        end else begin
                            fin  <= 1'b0;
                            busy <= 1'b1;
                            idx  <= top - 1'b1;
                            kind <= OPK_DBL;
                        end
                    end
                end
            end else if (last) begin
                qx <= rx;
                qy <= ry;
                qz <= rz;
                if ((kind == OPK_DBL) && k[idx]) begin
                    kind <= OPK_ADD;
                end else if (idx == '0) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end else begin
                    idx  <= idx - 1'b1;
                    kind <= OPK_DBL;
                end
            end
        end
    end

    assert_fin_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> !busy);

    assert_add_on_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (kind == OPK_ADD)) |-> k[idx]);

    assert_q_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> ($stable(qx) && $stable(qy) && $stable(qz)));

    assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(idx) && $stable(busy) && $stable(fin) && $stable(qx)));
endmodule

// File: rtl/ecsm_sequencer.sv
// Top level: scalar multiplication sequencer. Joins the host port, the
// scan controller and the slot timer, and drives the point-operation unit.
// Assumes the point unit delivers its result within OP_CYCLES clocks.
module ecsm_sequencer
    import ecsm_pkg::*;
#(
    parameter int FIELD_W   = 163,
    parameter int SCALAR_W  = 163,
    parameter int OP_CYCLES = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [3:0]         mode,
    input  logic [31:0]        din,
    output logic [31:0]        dout,
    output logic               op_stat,
    output logic               fin,
    output logic               pu_start,
    output logic               pu_dbl,
    output logic               pu_add,
    output logic [FIELD_W-1:0] pu_d,
    output logic [FIELD_W-1:0] pu_px,
    output logic [FIELD_W-1:0] pu_py,
    output logic [FIELD_W-1:0] pu_pz,
    output logic [FIELD_W-1:0] pu_qx,
    output logic [FIELD_W-1:0] pu_qy,
    output logic [FIELD_W-1:0] pu_qz,
    input  logic [FIELD_W-1:0] pu_rx,
    input  logic [FIELD_W-1:0] pu_ry,
    input  logic [FIELD_W-1:0] pu_rz
);
    logic                busy;
    logic                run_req;
    logic                launch;
    logic                t_active;
    logic                t_first;
    logic                t_last;
    logic [SCALAR_W-1:0] scalar;
    op_kind_e            kind;

    ecsm_host_port #(.FW(FIELD_W), .KW(SCALAR_W), .BUS(32)) u_host (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .din(din),
        .busy(busy), .qx(pu_qx), .qy(pu_qy), .qz(pu_qz),
        .d(pu_d), .px(pu_px), .py(pu_py), .pz(pu_pz), .k(scalar),
        .dout(dout), .run_req(run_req)
    );

    ecsm_scan_fsm #(.FW(FIELD_W), .KW(SCALAR_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .en(en), .run_req(run_req), .k(scalar),
        .px(pu_px), .py(pu_py), .pz(pu_pz),
        .rx(pu_rx), .ry(pu_ry), .rz(pu_rz),
        .last(t_last), .launch(launch), .kind(kind), .busy(busy), .fin(fin),
        .qx(pu_qx), .qy(pu_qy), .qz(pu_qz)
    );

    ecsm_op_timer #(.CYC(OP_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(en), .launch(launch),
        .active(t_active), .first(t_first), .last(t_last)
    );

    assign pu_start = t_first;
    assign pu_dbl   = t_active && (kind == OPK_DBL);
    assign pu_add   = t_active && (kind == OPK_ADD);
    assign op_stat  = t_last && en;

    assert_one_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pu_start |-> (pu_dbl ^ pu_add));

    assert_add_after_dbl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pu_add) |-> $past(pu_dbl));
endmodule

// File: tb/ecsm_sequencer_test.sv
`timescale 1ns/1ps
module ecsm_sequencer_test;
    localparam int N  = 40;
    localparam int KB = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b1;
    logic [3:0]   mode = 4'd0;
    logic [31:0]  din = '0;
    logic [31:0]  dout;
    logic         op_stat, fin, pu_start, pu_dbl, pu_add;
    logic [N-1:0] pu_d, pu_px, pu_py, pu_pz, pu_qx, pu_qy, pu_qz;
    logic [N-1:0] pu_rx = '0, pu_ry = '0, pu_rz = '0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int op_count = 0;
    int slot_err = 0;
    int flag_err = 0;
    int gap = 0;
    bit seen = 0;

    always #2.5 clk = ~clk;

    ecsm_sequencer #(.FIELD_W(N), .SCALAR_W(KB), .OP_CYCLES(20)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .din(din), .dout(dout),
        .op_stat(op_stat), .fin(fin), .pu_start(pu_start), .pu_dbl(pu_dbl),
        .pu_add(pu_add), .pu_d(pu_d), .pu_px(pu_px), .pu_py(pu_py), .pu_pz(pu_pz),
        .pu_qx(pu_qx), .pu_qy(pu_qy), .pu_qz(pu_qz),
        .pu_rx(pu_rx), .pu_ry(pu_ry), .pu_rz(pu_rz)
    );

    // Point unit model: doubling doubles X,Y and bumps Z by 1; addition adds P and bumps Z by 256.
    always @(posedge clk) begin
        if (pu_start) begin
            pu_rx <= pu_add ? pu_qx + pu_px : pu_qx << 1;
            pu_ry <= pu_add ? pu_qy + pu_py : pu_qy << 1;
            pu_rz <= pu_qz + (pu_add ? N'(256) : N'(1));
        end
    end

    // Slot spacing, status timing, flag and operation count monitor.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && en) begin
            if (fin) seen = 0;
            if (pu_start) begin
                if (seen && gap != 20) slot_err++;
                if (pu_dbl == pu_add) flag_err++;
                seen = 1;
                gap = 1;
            end else begin
                gap++;
            end
            if (op_stat) begin
                op_count++;
                if (gap != 20) slot_err++;
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [3:0] code, input logic [63:0] val, input int words);
        for (int w = 0; w < words; w++) begin
            @(negedge clk);
            mode = code;
            din = val[w*32 +: 32];
        end
        @(negedge clk);
        mode = 4'd0;
        din = '0;
    endtask

    task automatic read(input logic [3:0] code, output logic [63:0] val);
        @(negedge clk);
        mode = code;
        @(negedge clk);
        val[31:0] = dout;
        @(negedge clk);
        val[63:32] = dout;
        mode = 4'd0;
    endtask

    task automatic run_k(input logic [7:0] k);
        int n;
        load(4'd5, {56'd0, k}, 1);
        @(negedge clk);
        op_count = 0;
        mode = 4'd8;
        @(negedge clk);
        mode = 4'd0;
        n = 0;
        while (!fin && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic int top_bit(input logic [7:0] k);
        int t = 0;
        for (int i = 0; i < 8; i++) if (k[i]) t = i;
        return t;
    endfunction

    task automatic check_result(input string req, input logic [7:0] k,
                                input logic [N-1:0] px, input logic [N-1:0] py,
                                input logic [N-1:0] pz);
        logic [63:0] vx, vy, vz;
        logic [N-1:0] ex, ey, ez;
        int t, pop, ops;
        t = top_bit(k);
        pop = $countones(k);
        ops = (k == 0) ? 0 : t + pop - 1;
        ex = N'(k) * px;
        ey = N'(k) * py;
        ez = (k == 0) ? '0 : pz + N'(t) + (N'(pop - 1) << 8);
        read(4'd9, vx);
        read(4'd10, vy);
        read(4'd11, vz);
        check({req, " x"}, vx, {24'd0, ex});
        check({req, " y"}, vy, {24'd0, ey});
        check({req, " z/op mix"}, vz, {24'd0, ez});
        check({req, " op count"}, 64'(op_count), 64'(ops));
        check({req, " fin"}, {63'd0, fin}, 64'd1);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        wait (cyc >= 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] v;
        logic [N-1:0] px0, py0, pz0;
        int hold_err;
        px0 = 40'h12_3456_789B;
        py0 = 40'h00_0BAD_CAFE;
        pz0 = 40'h00_0000_0001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R8, R2)
        check("R8 fin after reset", {63'd0, fin}, 64'd0);
        check("R2 dout after reset", {32'd0, dout}, 64'd0);
        check("R4 pu_start after reset", {63'd0, pu_start}, 64'd0);

        // Loads with padding ones in the top word (R1)
        load(4'd1, 64'hFFFF_FFA5_1234_5678, 2);
        check("R1 d load", {24'd0, pu_d}, 64'h00_0000_00A5_1234_5678);
        load(4'd2, {24'hFFFFFF, px0}, 2);
        load(4'd3, {24'hABCDEF, py0}, 2);
        load(4'd4, {24'h000000, pz0}, 2);
        check("R1 px load masked", {24'd0, pu_px}, {24'd0, px0});
        check("R1 py load masked", {24'd0, pu_py}, {24'd0, py0});

        // Scalar one: Q = P, no operation (R9, R2)
        run_k(8'd1);
        read(4'd9, v);
        check("R9 k=1 Qx with R2 top-word mask", v, {24'd0, px0});
        check("R9 k=1 no ops", 64'(op_count), 64'd0);

        // Full sweep over every 8-bit scalar (R3, R5, R9)
        for (int k = 0; k < 256; k++) begin
            run_k(8'(k));
            check_result((k < 2) ? "R9 sweep" : "R3 sweep", 8'(k), px0, py0, pz0);
        end
        check("R5 slot length and status timing", 64'(slot_err), 64'd0);
        check("R4 flag per slot", 64'(flag_err), 64'd0);

        // Loads and restart ignored mid-run (R7)
        load(4'd5, 64'h55, 1);
        @(negedge clk);
        op_count = 0;
        mode = 4'd8;
        @(negedge clk);
        mode = 4'd0;
        repeat (30) @(negedge clk);
        load(4'd2, 64'h0000_0011_1111_1111, 2);
        @(negedge clk);
        mode = 4'd8;
        @(negedge clk);
        mode = 4'd0;
        while (!fin) @(negedge clk);
        check("R7 px unchanged by mid-run load", {24'd0, pu_px}, {24'd0, px0});
        check_result("R7 ignored restart", 8'h55, px0, py0, pz0);

        // Enable low: load has no effect (R6)
        @(negedge clk);
        en = 1'b0;
        mode = 4'd2;
        din = 32'hDEAD_BEEF;
        repeat (2) @(negedge clk);
        mode = 4'd0;
        en = 1'b1;
        @(negedge clk);
        check("R6 px unchanged while disabled", {24'd0, pu_px}, {24'd0, px0});

        // Enable low mid-run freezes progress (R6)
        load(4'd5, 64'h81, 1);
        @(negedge clk);
        op_count = 0;
        mode = 4'd8;
        @(negedge clk);
        mode = 4'd0;
        repeat (30) @(negedge clk);
        en = 1'b0;
        hold_err = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (fin !== 1'b0 || op_stat !== 1'b0) hold_err++;
        end
        en = 1'b1;
        check("R6 status held while disabled", 64'(hold_err), 64'd0);
        while (!fin) @(negedge clk);
        check_result("R6 resumed run", 8'h81, px0, py0, pz0);

        // Holding the start code does not restart (R10)
        load(4'd5, 64'h03, 1);
        @(negedge clk);
        op_count = 0;
        mode = 4'd8;
        repeat (150) @(negedge clk);
        check("R10 single run while code held", 64'(op_count), 64'd2);
        check("R10 fin stays high", {63'd0, fin}, 64'd1);
        mode = 4'd0;
        @(negedge clk);
        check_result("R10 result", 8'h03, px0, py0, pz0);
        check("R5 slot length overall", 64'(slot_err), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule